// File: doc/BRIEF.md
# Three-Port Class-Constrained Dispatch Scheduler

This block picks micro-ops out of a small reservation station and sends at most one of them to each of three execution ports per clock. Every port carries an integer ALU, so plain integer work can leave on all three ports at once. Port 0 also hosts the jump unit. The floating-point units are not interchangeable. The FPU on port 1 is the only one that accepts adds, and the FPU on port 2 is the only one that accepts multiplies. Moves have port 0 as their home FPU and may borrow the other two only when no ready add or multiply wants them. Vector integer and packed single-precision work is tagged with one of the FPU classes by the front end.

Micro-ops are written one per cycle into a slot named by the writer. Each write carries a class code, a latency and a ready flag. A ready mask can later mark waiting entries as ready. Each port grants its oldest eligible entry, with age taken from an allocation sequence number. Ports are served in the order 0, 1, 2, and an entry granted to a lower port is hidden from the higher ones. A granted entry is freed at the next clock edge.

Each FPU has a small occupancy state machine with two states, `OCC_IDLE` and `OCC_BUSY`. The transition idle-to-busy fires when an FPU op with latency L of 2 or more is granted; it loads a counter with L-1. The busy-to-busy transition decrements the counter. The busy-to-idle transition fires when the counter reads 1. While busy, the port refuses FPU-class ops but keeps granting integer ops to its ALU.

Top module: `dispatch_sched`

## Requirements
- R1: After reset the station is empty and no port asserts a dispatch.
- R2: A write to a free slot becomes a candidate one cycle after the write edge, but only once it is ready: either through the write's ready flag or through a later ready-mask bit. A write aimed at an occupied slot is ignored and does not alter the class, latency or ready state of that slot.
- R3: Class code 0 (integer) may go to any port, with unit code 0 (ALU). Three ready integer ops dispatch in the same cycle.
- R4: Class code 1 (branch) dispatches only on port 0, with unit code 1 (jump), and takes that port's single slot.
- R5: Class code 3 (FP add) dispatches only on port 1, and class code 4 (FP multiply) only on port 2, both with unit code 2 (FPU).
- R6: Class code 2 (FP move) may dispatch to the FPU of port 0. It may take the FPU of port 1 or port 2 only in a cycle where no ready add (for port 1) or multiply (for port 2) exists.
- R7: Each port grants the oldest eligible ready entry by allocation order, which stays correct across sequence wrap. Ports choose in the order 0, 1, 2, and an entry is never granted to two ports.
- R8: An FPU op of latency L, where L is 2 or more, blocks further FPU-class grants on that port for the L-1 cycles after its dispatch cycle. Latency 1 blocks nothing.
- R9: While a port's FPU is blocked, integer ops keep dispatching on that port.
- R10: A dispatched entry is freed and is never dispatched a second time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write a micro-op into the station |
| wr_idx | input | IDX_W | Target slot of the write |
| wr_class | input | 3 | Class code (0 int, 1 branch, 2 move, 3 add, 4 mul) |
| wr_lat | input | LAT_W | Execution latency in cycles |
| wr_ready | input | 1 | Operands already available at write |
| ready_set | input | ENTRIES | Marks valid entries as ready |
| disp_vld | output | 3 | Per-port dispatch valid |
| disp_idx | output | 3*IDX_W | Per-port granted slot, port p at bits p*IDX_W |
| disp_unit | output | 6 | Per-port unit code (0 ALU, 1 jump, 2 FPU), port p at bits 2p |

## Verification
The bench uses the defaults: eight entries and a 4-bit latency. With these values every slot can be filled, and a latency of 4 holds an FPU busy for three cycles, which leaves room to show integer ops passing the busy unit. Because the 5-bit sequence counter wraps after 32 accepted writes, the bench places an age race right across the wrap point. The scoreboard stamps every expected grant with its exact cycle, so it catches a busy window that is off by one as well as a wrong port or slot.

// File: rtl/sched_pkg.sv
package sched_pkg;
    typedef enum logic [2:0] {
        CLS_INT  = 3'd0,
        CLS_BR   = 3'd1,
        CLS_FMOV = 3'd2,
        CLS_FADD = 3'd3,
        CLS_FMUL = 3'd4
    } op_class_e;

    typedef enum logic [1:0] {
        U_ALU = 2'd0,
        U_JMP = 2'd1,
        U_FPU = 2'd2
    } unit_e;

    typedef enum logic {
        OCC_IDLE = 1'b0,
        OCC_BUSY = 1'b1
    } occ_state_e;
endpackage

// File: rtl/sched_age_pick.sv
module sched_age_pick #(
    parameter int N     = 8,
    parameter int SEQ_W = 5
) (
    input  logic [N-1:0]       cand,
    input  logic [N*SEQ_W-1:0] seq_flat,
    output logic [N-1:0]       grant
);
    // entry i wins when every other candidate j is younger (i - j wraps negative)
    always_comb begin
        for (int i = 0; i < N; i++) begin
            grant[i] = cand[i];
            for (int j = 0; j < N; j++) begin
                logic [SEQ_W-1:0] diff;
                diff = seq_flat[i*SEQ_W +: SEQ_W] - seq_flat[j*SEQ_W +: SEQ_W];
                if (j != i && cand[j] && !diff[SEQ_W-1])
                    grant[i] = 1'b0;
            end
        end
    end

    always_comb begin
        p_onehot_grant_r7: assert ($onehot0(grant))
            else $error("R7: more than one entry granted on a port");
    end
endmodule

// File: rtl/sched_fpu_occ.sv
module sched_fpu_occ
    import sched_pkg::*;
#(
    parameter int LAT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic [LAT_W-1:0] lat,
    output logic             busy
);
    occ_state_e       state_q, state_d;
    logic [LAT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OCC_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            OCC_IDLE: if (issue && lat > LAT_W'(1)) begin
                state_d = OCC_BUSY;
                cnt_d   = lat - LAT_W'(1);
            end
            OCC_BUSY: if (cnt_q <= LAT_W'(1)) begin
                state_d = OCC_IDLE;
                cnt_d   = '0;
            end else begin
                cnt_d = cnt_q - LAT_W'(1);
            end
            default: begin
                state_d = OCC_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb busy = (state_q == OCC_BUSY);

    p_no_fpu_issue_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !issue)
        else $error("R8: FPU op granted while the unit is occupied");

    p_busy_countdown_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OCC_BUSY && cnt_q > LAT_W'(1)) |=> (state_q == OCC_BUSY && cnt_q == $past(cnt_q) - LAT_W'(1)))
        else $error("R8: occupancy counter did not step down");
endmodule

// File: rtl/dispatch_sched.sv
module dispatch_sched
    import sched_pkg::*;
#(
    parameter int ENTRIES   = 8,
    parameter int LAT_W     = 4,
    localparam int IDX_W    = $clog2(ENTRIES),
    localparam int NPORT    = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [2:0]             wr_class,
    input  logic [LAT_W-1:0]       wr_lat,
    input  logic                   wr_ready,
    input  logic [ENTRIES-1:0]     ready_set,
    output logic [NPORT-1:0]       disp_vld,
    output logic [NPORT*IDX_W-1:0] disp_idx,
    output logic [NPORT*2-1:0]     disp_unit
);
    localparam int SEQ_W = IDX_W + 2;

    // station state
    logic [ENTRIES-1:0]     ent_vld, ent_rdy;
    op_class_e              ent_cls [ENTRIES];
    logic [LAT_W-1:0]       ent_lat [ENTRIES];
    logic [SEQ_W-1:0]       ent_seq [ENTRIES];
    logic [SEQ_W-1:0]       alloc_seq;
    logic [ENTRIES*SEQ_W-1:0] seq_flat;

    // selection
    logic [ENTRIES-1:0] rdy_mask, is_int, is_br, is_mov, is_add, is_mul;
    logic [ENTRIES-1:0] cand0, cand1, cand2, grant0, grant1, grant2, freed;
    logic [ENTRIES-1:0] gr [NPORT];
    logic               any_add, any_mul;
    logic [NPORT-1:0]   fpu_busy, fp_issue;

    logic [NPORT-1:0]   vld_a;
    logic [IDX_W-1:0]   sel_idx [NPORT];
    op_class_e          sel_cls [NPORT];
    logic [LAT_W-1:0]   sel_lat [NPORT];
    unit_e              unit_a  [NPORT];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        assign seq_flat[i*SEQ_W +: SEQ_W] = ent_seq[i];
        assign is_int[i] = (ent_cls[i] == CLS_INT);
        assign is_br[i]  = (ent_cls[i] == CLS_BR);
        assign is_mov[i] = (ent_cls[i] == CLS_FMOV);
        assign is_add[i] = (ent_cls[i] == CLS_FADD);
        assign is_mul[i] = (ent_cls[i] == CLS_FMUL);
    end

    assign rdy_mask = ent_vld & ent_rdy;
    assign any_add  = |(rdy_mask & is_add);
    assign any_mul  = |(rdy_mask & is_mul);

    // port 0: ALU, jump unit, home FPU for moves
    assign cand0 = rdy_mask & (is_int | is_br | (is_mov & {ENTRIES{!fpu_busy[0]}}));
    // port 1: ALU, add FPU; moves borrow it only with no ready add
    assign cand1 = rdy_mask & ~grant0 &
                   (is_int | ((is_add | (is_mov & {ENTRIES{!any_add}})) & {ENTRIES{!fpu_busy[1]}}));
    // port 2: ALU, multiply FPU; moves borrow it only with no ready multiply
    assign cand2 = rdy_mask & ~grant0 & ~grant1 &
                   (is_int | ((is_mul | (is_mov & {ENTRIES{!any_mul}})) & {ENTRIES{!fpu_busy[2]}}));

    sched_age_pick #(.N(ENTRIES), .SEQ_W(SEQ_W)) u_pick0 (.cand(cand0), .seq_flat(seq_flat), .grant(grant0));
    sched_age_pick #(.N(ENTRIES), .SEQ_W(SEQ_W)) u_pick1 (.cand(cand1), .seq_flat(seq_flat), .grant(grant1));
    sched_age_pick #(.N(ENTRIES), .SEQ_W(SEQ_W)) u_pick2 (.cand(cand2), .seq_flat(seq_flat), .grant(grant2));

    assign gr[0] = grant0;
    assign gr[1] = grant1;
    assign gr[2] = grant2;
    assign freed = grant0 | grant1 | grant2;

    // state register process: station entries and allocation order
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_vld   <= '0;
            ent_rdy   <= '0;
            alloc_seq <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                ent_cls[i] <= CLS_INT;
                ent_lat[i] <= '0;
                ent_seq[i] <= '0;
            end
        end else begin
            if (wr_en && !ent_vld[wr_idx])
                alloc_seq <= alloc_seq + SEQ_W'(1);
            for (int i = 0; i < ENTRIES; i++) begin
                if (ent_vld[i]) begin
                    if (freed[i]) begin
                        ent_vld[i] <= 1'b0;
                        ent_rdy[i] <= 1'b0;
                    end else if (ready_set[i]) begin
                        ent_rdy[i] <= 1'b1;
                    end
                end else if (wr_en && wr_idx == IDX_W'(i)) begin
                    ent_vld[i] <= 1'b1;
                    ent_rdy[i] <= wr_ready;
                    ent_cls[i] <= op_class_e'(wr_class);
                    ent_lat[i] <= wr_lat;
                    ent_seq[i] <= alloc_seq;
                end
            end
        end
    end

    // output process: encode grant, pick unit
    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            vld_a[p]   = |gr[p];
            sel_idx[p] = '0;
            sel_cls[p] = CLS_INT;
            sel_lat[p] = '0;
            for (int i = 0; i < ENTRIES; i++) begin
                if (gr[p][i]) begin
                    sel_idx[p] = IDX_W'(i);
                    sel_cls[p] = ent_cls[i];
                    sel_lat[p] = ent_lat[i];
                end
            end
            unique case (sel_cls[p])
                CLS_INT: unit_a[p] = U_ALU;
                CLS_BR:  unit_a[p] = U_JMP;
                default: unit_a[p] = U_FPU;
            endcase
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign disp_vld[p]                 = vld_a[p];
        assign disp_idx[p*IDX_W +: IDX_W]  = sel_idx[p];
        assign disp_unit[p*2 +: 2]         = unit_a[p];
        assign fp_issue[p]                 = vld_a[p] && (unit_a[p] == U_FPU);

        sched_fpu_occ #(.LAT_W(LAT_W)) u_occ (
            .clk   (clk),
            .rst_n (rst_n),
            .issue (fp_issue[p]),
            .lat   (sel_lat[p]),
            .busy  (fpu_busy[p])
        );

        p_entry_freed_r10: assert property (@(posedge clk) disable iff (!rst_n)
            vld_a[p] |=> !ent_vld[$past(sel_idx[p])])
            else $error("R10: dispatched entry still valid");
    end

    p_branch_port0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_a[1] || vld_a[2]) |-> (unit_a[1] != U_JMP && unit_a[2] != U_JMP))
        else $error("R4: branch left on a port other than 0");

    p_add_on_port1_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_a[1] && unit_a[1] == U_FPU) |-> (sel_cls[1] == CLS_FADD || sel_cls[1] == CLS_FMOV))
        else $error("R5: wrong FPU class on port 1");

    p_mul_on_port2_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_a[2] && unit_a[2] == U_FPU) |-> (sel_cls[2] == CLS_FMUL || sel_cls[2] == CLS_FMOV))
        else $error("R5: wrong FPU class on port 2");

    p_mov_yields_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_a[1] && sel_cls[1] == CLS_FMOV) |-> !any_add)
        else $error("R6: move took the add FPU while an add was ready");

    p_distinct_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_a[0] && vld_a[1]) |-> (sel_idx[0] != sel_idx[1]))
        else $error("R7: one entry granted to two ports");

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (disp_vld == '0))
        else $error("R1: dispatch right after reset");
endmodule

// File: tb/tb_dispatch_sched.sv
`timescale 1ns/1ps
module tb_dispatch_sched;
    localparam int ENTRIES = 8;
    localparam int LAT_W   = 4;
    localparam int IDX_W   = 3;
    localparam int C_INT = 0, C_BR = 1, C_MOV = 2, C_ADD = 3, C_MUL = 4;
    localparam int U_ALU = 0, U_JMP = 1, U_FPU = 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               wr_en = 1'b0;
    logic [IDX_W-1:0]   wr_idx = '0;
    logic [2:0]         wr_class = '0;
    logic [LAT_W-1:0]   wr_lat = '0;
    logic               wr_ready = 1'b0;
    logic [ENTRIES-1:0] ready_set = '0;
    logic [2:0]         disp_vld;
    logic [3*IDX_W-1:0] disp_idx;
    logic [5:0]         disp_unit;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct {
        int    port;
        int    idx;
        int    unit;
        int    when;
        string req;
    } exp_t;
    exp_t sb[$];

    dispatch_sched #(.ENTRIES(ENTRIES), .LAT_W(LAT_W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_class(wr_class), .wr_lat(wr_lat), .wr_ready(wr_ready),
        .ready_set(ready_set), .disp_vld(disp_vld), .disp_idx(disp_idx),
        .disp_unit(disp_unit)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compares every grant against the scoreboard head
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int p = 0; p < 3; p++) begin
                if (disp_vld[p]) begin
                    int a_idx, a_unit;
                    a_idx  = int'(disp_idx[p*IDX_W +: IDX_W]);
                    a_unit = int'(disp_unit[p*2 +: 2]);
                    checks++;
                    if (sb.size() == 0) begin
                        errors++;
                        $display("FAIL R10: unexpected grant port=%0d idx=%0d unit=%0d cyc=%0d, expected none",
                                 p, a_idx, a_unit, cyc);
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        if (e.port != p || e.idx != a_idx || e.unit != a_unit || e.when != cyc) begin
                            errors++;
                            $display("FAIL %s: got port=%0d idx=%0d unit=%0d cyc=%0d, expected port=%0d idx=%0d unit=%0d cyc=%0d",
                                     e.req, p, a_idx, a_unit, cyc, e.port, e.idx, e.unit, e.when);
                        end
                    end
                end
            end
        end
    end

    task automatic expect_grant(int port, int idx, int unit, int delay, string req);
        exp_t e;
        e.port = port; e.idx = idx; e.unit = unit; e.when = cyc + delay; e.req = req;
        sb.push_back(e);
    endtask

    task automatic put(int idx, int cls, int lat, bit rdy);
        wr_en    = 1'b1;
        wr_idx   = IDX_W'(idx);
        wr_class = 3'(cls);
        wr_lat   = LAT_W'(lat);
        wr_ready = rdy;
        @(negedge clk);
        wr_en    = 1'b0;
        wr_ready = 1'b0;
    endtask

    task automatic mark(logic [ENTRIES-1:0] m);
        ready_set = m;
        @(negedge clk);
        ready_set = '0;
    endtask

    task automatic drain(int n, string req);
        repeat (n) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL %s: %0d expected grants missing, first port=%0d idx=%0d cyc=%0d, expected queue empty",
                     req, sb.size(), sb[0].port, sb[0].idx, sb[0].when);
            sb.delete();
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run still active at cyc=%0d, expected completion", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: nothing dispatched after reset
        checks++;
        if (disp_vld != 3'b000) begin
            errors++;
            $display("FAIL R1: disp_vld=%b, expected 000", disp_vld);
        end

        // R3: three integer ops leave together, oldest on port 0
        put(0, C_INT, 1, 0); put(1, C_INT, 1, 0); put(2, C_INT, 1, 0);
        expect_grant(0, 0, U_ALU, 1, "R3");
        expect_grant(1, 1, U_ALU, 1, "R3");
        expect_grant(2, 2, U_ALU, 1, "R3");
        mark(8'h07);
        drain(6, "R3");

        // R2/R10: ready-on-write singles, slots reused, sequence advances
        for (int k = 0; k < 10; k++) begin
            expect_grant(0, k % 8, U_ALU, 1, "R2");
            put(k % 8, C_INT, 1, 1);
        end
        drain(6, "R10");

        // R7: age order, not slot order
        put(5, C_INT, 1, 0); put(3, C_INT, 1, 0); put(7, C_INT, 1, 0); put(1, C_INT, 1, 0);
        expect_grant(0, 5, U_ALU, 1, "R7");
        expect_grant(1, 3, U_ALU, 1, "R7");
        expect_grant(2, 7, U_ALU, 1, "R7");
        expect_grant(0, 1, U_ALU, 2, "R7");
        mark(8'hAA);
        drain(6, "R7");

        // R4: branches only on port 0
        put(0, C_BR, 1, 0); put(1, C_BR, 1, 0); put(2, C_INT, 1, 0);
        expect_grant(0, 0, U_JMP, 1, "R4");
        expect_grant(1, 2, U_ALU, 1, "R4");
        expect_grant(0, 1, U_JMP, 2, "R4");
        mark(8'h07);
        drain(6, "R4");

        // R5: multiply to port 2, add to port 1
        put(0, C_MUL, 1, 0); put(1, C_ADD, 1, 0);
        expect_grant(1, 1, U_FPU, 1, "R5");
        expect_grant(2, 0, U_FPU, 1, "R5");
        mark(8'h03);
        drain(6, "R5");

        // R6: moves yield port 1 to a ready add, borrow idle port 2
        put(0, C_ADD, 1, 0); put(1, C_MOV, 1, 0); put(2, C_MOV, 1, 0); put(3, C_MOV, 1, 0);
        expect_grant(0, 1, U_FPU, 1, "R6");
        expect_grant(1, 0, U_FPU, 1, "R6");
        expect_grant(2, 2, U_FPU, 1, "R6");
        expect_grant(0, 3, U_FPU, 2, "R6");
        mark(8'h0F);
        drain(6, "R6");

        // R8/R9: latency-4 multiply blocks port 2 FPU for 3 cycles, ALU keeps going
        put(1, C_MUL, 1, 0); put(2, C_INT, 1, 0); put(3, C_INT, 1, 0); put(4, C_INT, 1, 0);
        expect_grant(2, 0, U_FPU, 1, "R8");
        expect_grant(0, 2, U_ALU, 2, "R9");
        expect_grant(1, 3, U_ALU, 2, "R9");
        expect_grant(2, 4, U_ALU, 2, "R9");
        expect_grant(2, 1, U_FPU, 5, "R8");
        put(0, C_MUL, 4, 1);
        mark(8'h1E);
        drain(8, "R8");

        // R8/R7: latency-1 adds back to back, ages straddle the sequence wrap
        put(0, C_ADD, 1, 0); put(1, C_ADD, 1, 0);
        expect_grant(1, 0, U_FPU, 1, "R8");
        expect_grant(1, 1, U_FPU, 2, "R8");
        mark(8'h03);
        drain(6, "R7");

        // R2: write to an occupied slot is ignored (class stays int, not ready)
        put(0, C_INT, 1, 0);
        put(0, C_BR, 3, 1);
        drain(3, "R2");
        expect_grant(0, 0, U_ALU, 1, "R2");
        mark(8'h01);
        drain(6, "R2");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule